// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block links a synchronous host port to an asynchronous static RAM. The RAM has an address bus, a bidirectional data bus and three active-low strobes: select, read-drive and write. The host offers a request with a valid/ready handshake. Each request carries a direction flag, an address and write data. The controller turns every accepted request into a pin sequence whose phase lengths meet the memory's minimum timing. Each phase length is given as a time parameter in nanoseconds. It is rounded up to whole clock cycles using the clock-period parameter.

A write holds the address and select low for one cycle before the write strobe falls. The write strobe then stays low for the longest of the pulse-width, data-setup, address-to-end and cycle-time limits. The controller drives the data bus for exactly the cycles in which the write strobe is low, and keeps the read-drive strobe high for the whole write. A read holds select and read-drive low for the longest of the access-time limits and captures the bus on the final edge. It returns the result as a one-cycle pulse. A turnaround phase then waits for the memory's output float time before any later access.

Top module: `asram_ctrl`

## Requirements
- R1: During and directly after reset, sram_ce_n, sram_oe_n and sram_we_n are 1, the controller does not drive sram_dq, req_ready is 1 and rsp_valid is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the accepting edge until the access and its turnaround are over. With req_valid at 0 the strobes stay at 1.
- R3: For a write (req_we=1), the cycle after acceptance has sram_ce_n=0, sram_we_n=1 and sram_oe_n=1. sram_we_n is then 0 for exactly NWP = max(ceil(PWE/T), ceil(SD/T), ceil(WC/T)-1, ceil(AW/T)-1, 1) cycles. sram_oe_n stays 1 throughout. With defaults NWP = 2.
- R4: While sram_we_n is 0, sram_dq carries the accepted write data unchanged and sram_addr is stable. sram_we_n and sram_ce_n rise on the same edge, and the controller releases the bus on that edge. req_ready is 1 again NWP+1 cycles after acceptance.
- R5: For a read (req_we=0), sram_ce_n and sram_oe_n are 0 with the requested address for exactly NRD = max(ceil(AA/T), ceil(DOE/T), ceil(RC/T), 1) cycles. sram_we_n stays 1. With defaults NRD = 2.
- R6: rsp_valid is 1 for one cycle, NRD cycles after the accepting edge. rsp_rdata then holds the bus value sampled on the last edge of the read phase.
- R7: After sram_oe_n rises, the controller stays idle for NTA = ceil(HZOE/T) cycles before req_ready returns. At least NTA+1 cycles pass before sram_we_n can fall. With defaults NTA = 1.
- R8: sram_addr changes only on an accepting edge, so it is stable whenever sram_ce_n is 0 in two consecutive cycles.
- R9: A read returns the value most recently written to that address through the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | DATA_W | Read result |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output drive enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq | inout | DATA_W | Shared data bus |

## Verification
The assertions assume the memory drives sram_dq only while select and read-drive are both low and write is high. They also assume the host holds its request fields steady while req_valid waits for req_ready. The bench's memory model follows the first rule. The bench's stimulus tasks raise req_valid after a falling edge, keep the address, data and direction unchanged until the accepting edge, and change those fields freely only while req_valid is low.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WADDR,
      ST_WPULSE,
      ST_RACC,
      ST_TURN
   } ctl_state_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic drv;
   } pin_set_t;

   function automatic int ns_to_cyc(input int ns, input int per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic pin_set_t pins_for(input ctl_state_e st);
      pin_set_t p;
      p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
      case (st)
         ST_WADDR:  p.ce_n = 1'b0;
         ST_WPULSE: begin
            p.ce_n = 1'b0;
            p.we_n = 1'b0;
            p.drv  = 1'b1;
         end
         ST_RACC: begin
            p.ce_n = 1'b0;
            p.oe_n = 1'b0;
         end
         default: ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign last = (cnt == CNT_W'(1));

   // counter parks at zero and never wraps (phase lengths, R3 R5 R7)
   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> (cnt == '0));

endmodule

// File: rtl/asram_dq_path.sv
module asram_dq_path #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv,
   input  logic [DATA_W-1:0] wdata,
   input  logic              capture,
   inout  wire  [DATA_W-1:0] sram_dq,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   assign sram_dq = drv ? wdata : {DATA_W{1'bz}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= capture;
         if (capture)
            rdata <= sram_dq;
      end
   end

   p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

   p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drv && $past(drv)) |-> $stable(wdata));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int T_RC_NS   = 15,
   parameter int T_AA_NS   = 15,
   parameter int T_DOE_NS  = 10,
   parameter int T_WC_NS   = 15,
   parameter int T_PWE_NS  = 12,
   parameter int T_SD_NS   = 10,
   parameter int T_AW_NS   = 12,
   parameter int T_HZOE_NS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   inout  wire  [DATA_W-1:0] sram_dq
);

   localparam int N_RD  = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)),
                               imax(ns_to_cyc(T_RC_NS, CLK_NS), 1));
   localparam int N_WP  = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                               imax(imax(ns_to_cyc(T_WC_NS, CLK_NS) - 1,
                                         ns_to_cyc(T_AW_NS, CLK_NS) - 1), 1));
   localparam int N_TA  = ns_to_cyc(T_HZOE_NS, CLK_NS);
   localparam int N_MAX = imax(imax(N_RD, N_WP), N_TA);
   localparam int CNT_W = $clog2(N_MAX + 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("asram_ctrl: CLK_NS must be positive");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctrl: bus widths must be positive");
      end
   endgenerate

   ctl_state_e       state, nxt;
   pin_set_t         pins_q;
   logic             t_last, t_load, capture;
   logic [CNT_W-1:0] t_val;
   logic [DATA_W-1:0] wdata_q;
   logic             accept;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   // phase after a read: turnaround phase only when float time is non-zero
   generate
      if (N_TA > 0) begin : g_turn
         always_comb begin
            nxt     = state;
            capture = 1'b0;
            unique case (state)
               ST_IDLE:   if (req_valid) nxt = req_we ? ST_WADDR : ST_RACC;
               ST_WADDR:  nxt = ST_WPULSE;
               ST_WPULSE: if (t_last) nxt = ST_IDLE;
               ST_RACC:   if (t_last) begin capture = 1'b1; nxt = ST_TURN; end
               ST_TURN:   if (t_last) nxt = ST_IDLE;
               default:   nxt = ST_IDLE;
            endcase
         end
      end else begin : g_no_turn
         always_comb begin
            nxt     = state;
            capture = 1'b0;
            unique case (state)
               ST_IDLE:   if (req_valid) nxt = req_we ? ST_WADDR : ST_RACC;
               ST_WADDR:  nxt = ST_WPULSE;
               ST_WPULSE: if (t_last) nxt = ST_IDLE;
               ST_RACC:   if (t_last) begin capture = 1'b1; nxt = ST_IDLE; end
               default:   nxt = ST_IDLE;
            endcase
         end
      end
   endgenerate

   always_comb begin
      t_load = (nxt != state);
      unique case (nxt)
         ST_WPULSE: t_val = CNT_W'(N_WP);
         ST_RACC:   t_val = CNT_W'(N_RD);
         ST_TURN:   t_val = CNT_W'(N_TA);
         default:   t_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pins_q    <= pins_for(ST_IDLE);
         sram_addr <= '0;
         wdata_q   <= '0;
      end else begin
         state  <= nxt;
         pins_q <= pins_for(nxt);
         if (accept) begin
            sram_addr <= req_addr;
            wdata_q   <= req_wdata;
         end
      end
   end

   assign sram_ce_n = pins_q.ce_n;
   assign sram_oe_n = pins_q.oe_n;
   assign sram_we_n = pins_q.we_n;

   asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   asram_dq_path #(.DATA_W(DATA_W)) u_dq (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv     (pins_q.drv),
      .wdata   (wdata_q),
      .capture (capture),
      .sram_dq (sram_dq),
      .rdata   (rsp_rdata),
      .rvalid  (rsp_valid)
   );

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n));

   p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_oe_n && !sram_ce_n));

   p_we_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> ($past(!sram_ce_n) && $past(sram_oe_n)));

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pins_q.drv |-> sram_oe_n);

   p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |=> !pins_q.drv);

endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int TP = 10;

   function automatic int cdiv(input int ns);
      return (ns + TP - 1) / TP;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int B_NRD = mx(mx(cdiv(15), cdiv(10)), mx(cdiv(15), 1));
   localparam int B_NWP = mx(mx(cdiv(12), cdiv(10)), mx(mx(cdiv(15) - 1, cdiv(12) - 1), 1));
   localparam int B_NTA = cdiv(8);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_oe_n, sram_we_n;
   wire  [DW-1:0] sram_dq;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [DW-1:0] mem     [2**AW];
   logic [DW-1:0] ref_mem [2**AW];

   always #5 clk = ~clk;

   asram_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq(sram_dq)
   );

   // behavioural memory: drives only while selected, output-enabled, not writing
   assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : {DW{1'bz}};

   function automatic logic [DW-1:0] init_val(input int a);
      return DW'(a) ^ 8'hA5;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // pin monitor and memory rule checker, sampled mid-cycle
   logic          p_we_low, p_oe_low, p_ce_low;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_dq;
   int            pw, rdlen, since_oe;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2**AW; i++) mem[i] <= init_val(i);
         p_we_low <= 1'b0; p_oe_low <= 1'b0; p_ce_low <= 1'b0;
         p_addr <= '0; p_dq <= '0;
         pw <= 0; rdlen <= 0; since_oe <= 100;
      end else begin
         if (!sram_we_n) begin
            if (!sram_oe_n) chk(0, "R3 oe_n low during write", 0, 1);
            if (p_we_low) begin
               if (sram_dq !== p_dq) chk(0, "R4 write data moved", int'(sram_dq), int'(p_dq));
               if (sram_addr !== p_addr) chk(0, "R4 addr moved in write", int'(sram_addr), int'(p_addr));
            end else begin
               chk(since_oe >= B_NTA + 1, "R7 turnaround before write", since_oe, B_NTA + 1);
            end
            pw <= pw + 1;
         end else if (p_we_low) begin
            chk(pw == B_NWP, "R3 write pulse length", pw, B_NWP);
            chk(sram_ce_n == 1'b1, "R4 ce_n rises with we_n", int'(sram_ce_n), 1);
            mem[p_addr] <= p_dq;
            pw <= 0;
         end
         if (!sram_oe_n) begin
            rdlen <= rdlen + 1;
            since_oe <= 0;
            if (sram_ce_n || !sram_we_n) chk(0, "R5 read strobes", int'({sram_ce_n, sram_we_n}), 1);
         end else begin
            if (p_oe_low) chk(rdlen == B_NRD, "R5 read phase length", rdlen, B_NRD);
            if (p_oe_low) rdlen <= 0;
            since_oe <= (since_oe < 100) ? since_oe + 1 : since_oe;
         end
         if (!sram_ce_n && p_ce_low && sram_addr !== p_addr)
            chk(0, "R8 addr changed while selected", int'(sram_addr), int'(p_addr));
         p_we_low <= !sram_we_n;
         p_oe_low <= !sram_oe_n;
         p_ce_low <= !sram_ce_n;
         p_addr   <= sram_addr;
         p_dq     <= sram_dq;
      end
   end

   task automatic issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_we = $urandom % 2; req_addr = $urandom; req_wdata = $urandom;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      issue(1'b1, a, d);
      // now at first negedge after the accepting edge
      chk(sram_ce_n == 0 && sram_we_n == 1 && sram_oe_n == 1, "R3 address setup cycle",
          int'({sram_ce_n, sram_we_n, sram_oe_n}), 3'b011);
      chk(req_ready == 0, "R2 busy during write", int'(req_ready), 0);
      for (int i = 0; i < B_NWP; i++) begin
         @(negedge clk);
         chk(sram_we_n == 0 && sram_dq == d && sram_addr == a, "R4 write pulse bus",
             int'(sram_dq), int'(d));
      end
      @(negedge clk);
      chk(sram_we_n == 1 && req_ready == 1, "R4 write end and ready", int'({sram_we_n, req_ready}), 3);
      ref_mem[a] = d;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      issue(1'b0, a, '0);
      for (int i = 1; i <= B_NRD + B_NTA + 1; i++) begin
         if (i > 1) @(negedge clk);
         if (i <= B_NRD) begin
            chk(sram_oe_n == 0 && sram_ce_n == 0 && sram_addr == a, "R5 read strobes and address",
                int'({sram_ce_n, sram_oe_n}), 0);
            chk(rsp_valid == 0, "R6 no early response", int'(rsp_valid), 0);
         end
         if (i == B_NRD + 1) begin
            chk(rsp_valid == 1, "R6 response strobe", int'(rsp_valid), 1);
            chk(rsp_rdata == ref_mem[a], "R9 read data", int'(rsp_rdata), int'(ref_mem[a]));
         end
         if (i == B_NRD + 2)
            chk(rsp_valid == 0, "R6 single-cycle response", int'(rsp_valid), 0);
         if (i <= B_NRD + B_NTA)
            chk(req_ready == 0, "R7 busy through turnaround", int'(req_ready), 0);
         else
            chk(req_ready == 1, "R7 ready after turnaround", int'(req_ready), 1);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 2**AW; i++) ref_mem[i] = init_val(i);
      repeat (3) @(negedge clk);
      chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes in reset",
          int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
      chk(req_ready == 1 && rsp_valid == 0, "R1 handshake in reset", int'({req_ready, rsp_valid}), 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sram_ce_n && sram_oe_n && sram_we_n && req_ready, "R1 idle after reset",
          int'({sram_ce_n, sram_oe_n, sram_we_n, req_ready}), 15);

      // R2: fields toggling without valid must not start anything
      for (int i = 0; i < 5; i++) begin
         req_we = i[0]; req_addr = AW'(i * 37); req_wdata = DW'(i * 91);
         @(negedge clk);
         chk(sram_ce_n && sram_we_n && sram_oe_n && !rsp_valid, "R2 no access without valid",
             int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
      end

      // directed corners
      do_read(8'h00);                // reset content
      do_write(8'h00, 8'h00);
      do_write(8'hFF, 8'hFF);
      do_read(8'hFF);                // R7: read right after write
      do_write(8'h10, 8'h3C);        // R7: write right after read
      do_read(8'h00);
      do_read(8'h10);                // back-to-back reads, R8
      do_write(8'h10, 8'hC3);
      do_read(8'h10);

      // random mix over a small address window so reads hit writes
      for (int k = 0; k < 300; k++) begin
         logic [AW-1:0] a;
         a = AW'($urandom % 16);
         if ($urandom % 2) do_write(a, DW'($urandom));
         else              do_read(a);
         repeat ($urandom % 3) @(negedge clk);
      end

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule